// File: doc/BRIEF.md
# Multi-Event Packet Assembler

This block collects event fragments from an upstream fragment queue and bundles a chosen number of consecutive events into a single outgoing network packet. Bundling several events into one packet lowers the packet rate on the link and makes each packet larger. A fast trigger path would typically bundle 32 events per packet, and a slower high-level path 16.

Before it assembles a packet, the block takes one destination address from a destination queue. That queue is filled by a central decision source. If the queue is empty, the block does no work and asserts a throttle flag. The packet is built in an internal word buffer, so the total payload length is known when the header goes out. The block then streams the packet on a 32-bit ready/valid bus, in this order:

- the static header words, read from a small writable header table;
- the destination address;
- a length and count word;
- the first event number;
- each event, as a sub-header followed by its data;
- a closing marker word.

Start-of-packet and end-of-packet flags frame each packet on the stream.

Top module: `mep_framer`

## Requirements
- R1: While reset is asserted, and right after it with no destination pending, `out_valid`, `frag_ready` and `dst_ready` are low and `busy` is high.
- R2: While no destination address is available and no packet is in progress, the block accepts no fragment words, emits nothing and holds `busy` high.
- R3: `dst_ready` is raised only while `dst_valid` is high, and exactly one destination is consumed per packet.
- R4: A packet opens with the HDR_WORDS header-table words in increasing address order, followed by the destination address taken for that packet.
- R5: The word after the destination carries the payload length in 32-bit words in bits 31:16 and the event count in bits 15:0. The payload covers every event sub-header and every data word.
- R6: The next word carries the event number of the packet's first event in bits 31:16 and zero in bits 15:0.
- R7: Each event appears in arrival order as a sub-header word, with the fragment's data-word count in bits 31:16 and its event number in bits 15:0, followed by its data words unchanged. After the last word of a fragment, `frag_ready` is low for one cycle.
- R8: The final word of a packet equals the TRAILER parameter. `out_sop` is set only on the first word and `out_eop` only on the final word. `out_valid` drops for at least one cycle after the final word is taken.
- R9: The number of events per packet is read from `evt_per_pkt` on the cycle the destination is consumed, and later changes do not affect that packet. A value of 0 is treated as 1.
- R10: While `out_valid` is high and `out_ready` is low, the data and both framing flags hold their values. No word is lost or repeated.
- R11: No fragment word is accepted while a packet is being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_per_pkt | input | CNT_W | Events per packet, sampled at packet start |
| hdr_we | input | 1 | Header table write enable |
| hdr_waddr | input | clog2(HDR_WORDS) | Header table write address |
| hdr_wdata | input | DW | Header table write data |
| dst_valid | input | 1 | Destination queue not empty |
| dst_ready | output | 1 | Destination pop |
| dst_addr | input | DW | Destination address at the queue head |
| frag_valid | input | 1 | Fragment word available |
| frag_ready | output | 1 | Fragment word accepted |
| frag_data | input | DW | Fragment data word |
| frag_last | input | 1 | Last word of the current fragment |
| frag_evid | input | 16 | Event number, sampled on a fragment's first word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | DW | Output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| busy | output | 1 | Stalled for lack of a destination |

## Verification
The bench builds the block with four header words and a 64-word payload buffer. That lets a packet of 32 single-word events fill the buffer to its last slot, matching the fast-path bundling factor. With the 6-bit packing-factor port, the bench can exercise:

- factors of 0, 1, 2 and 3;
- a factor change in the middle of a packet;
- irregular fragment lengths;
- random downstream stalls.

// File: rtl/mep_pkg.sv
package mep_pkg;
  localparam int EVID_W = 16;
  localparam int LEN_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_CLOSE   = 2'd2,
    ST_SEND    = 2'd3
  } mep_state_e;
endpackage

// File: rtl/mep_word_ram.sv
module mep_word_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mep_tx_mux.sv
module mep_tx_mux #(
  parameter int          DW        = 32,
  parameter int          HDR_WORDS = 4,
  parameter int          HAW       = 2,
  parameter int          BAW       = 6,
  parameter int          PW        = 7,
  parameter int          IW        = 8,
  parameter logic [31:0] TRAILER   = 32'hE0F0_A55A
) (
  input  logic [IW-1:0]  idx,
  input  logic [PW-1:0]  wptr,
  input  logic [DW-1:0]  hdr_word,
  input  logic [DW-1:0]  dst_word,
  input  logic [DW-1:0]  len_word,
  input  logic [DW-1:0]  id_word,
  input  logic [DW-1:0]  buf_word,
  output logic [HAW-1:0] hdr_raddr,
  output logic [BAW-1:0] buf_raddr,
  output logic [DW-1:0]  data,
  output logic           sop,
  output logic           eop
);
  localparam int PRE = HDR_WORDS + 3;

  logic [IW-1:0] last_idx;

  always_comb begin
    last_idx  = IW'(PRE) + IW'(wptr);
    hdr_raddr = HAW'(idx);
    buf_raddr = BAW'(idx - IW'(PRE));
    sop       = (idx == '0);
    eop       = (idx == last_idx);
    if (idx < IW'(HDR_WORDS))            data = hdr_word;
    else if (idx == IW'(HDR_WORDS))      data = dst_word;
    else if (idx == IW'(HDR_WORDS + 1))  data = len_word;
    else if (idx == IW'(HDR_WORDS + 2))  data = id_word;
    else if (eop)                        data = DW'(TRAILER);
    else                                 data = buf_word;
  end
endmodule

// File: rtl/mep_framer.sv
module mep_framer #(
  parameter int          DW        = 32,
  parameter int          HDR_WORDS = 4,
  parameter int          BUF_DEPTH = 64,
  parameter int          CNT_W     = 6,
  parameter logic [31:0] TRAILER   = 32'hE0F0_A55A
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CNT_W-1:0]              evt_per_pkt,
  input  logic                          hdr_we,
  input  logic [$clog2(HDR_WORDS)-1:0]  hdr_waddr,
  input  logic [DW-1:0]                 hdr_wdata,
  input  logic                          dst_valid,
  output logic                          dst_ready,
  input  logic [DW-1:0]                 dst_addr,
  input  logic                          frag_valid,
  output logic                          frag_ready,
  input  logic [DW-1:0]                 frag_data,
  input  logic                          frag_last,
  input  logic [15:0]                   frag_evid,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DW-1:0]                 out_data,
  output logic                          out_sop,
  output logic                          out_eop,
  output logic                          busy
);
  import mep_pkg::*;

  localparam int HAW = $clog2(HDR_WORDS);
  localparam int BAW = $clog2(BUF_DEPTH);
  localparam int PW  = BAW + 1;
  localparam int IW  = $clog2(BUF_DEPTH + HDR_WORDS + 4) + 1;

  mep_state_e          state_q, state_d;
  logic [DW-1:0]       dst_q, dst_d;
  logic [CNT_W-1:0]    pack_q, pack_d, evcnt_q, evcnt_d;
  logic [PW-1:0]       wptr_q, wptr_d;
  logic [BAW-1:0]      slot_q, slot_d;
  logic                in_frag_q, in_frag_d;
  logic [EVID_W-1:0]   cur_evid_q, cur_evid_d, first_evid_q, first_evid_d;
  logic [LEN_W-1:0]    flen_q, flen_d;
  logic [IW-1:0]       idx_q, idx_d;

  logic                buf_we;
  logic [BAW-1:0]      buf_waddr, buf_raddr;
  logic [DW-1:0]       buf_wdata, buf_rdata;
  logic [HAW-1:0]      hdr_raddr;
  logic [DW-1:0]       hdr_rdata;
  logic [DW-1:0]       len_word, id_word;
  logic                tx_eop;

  mep_word_ram #(.DEPTH(HDR_WORDS), .DW(DW), .AW(HAW)) u_hdr (
    .clk(clk), .we(hdr_we), .waddr(hdr_waddr), .wdata(hdr_wdata),
    .raddr(hdr_raddr), .rdata(hdr_rdata)
  );

  mep_word_ram #(.DEPTH(BUF_DEPTH), .DW(DW), .AW(BAW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  assign len_word = DW'({LEN_W'(wptr_q), EVID_W'(evcnt_q)});
  assign id_word  = DW'({first_evid_q, 16'h0000});

  mep_tx_mux #(
    .DW(DW), .HDR_WORDS(HDR_WORDS), .HAW(HAW), .BAW(BAW),
    .PW(PW), .IW(IW), .TRAILER(TRAILER)
  ) u_mux (
    .idx(idx_q), .wptr(wptr_q), .hdr_word(hdr_rdata), .dst_word(dst_q),
    .len_word(len_word), .id_word(id_word), .buf_word(buf_rdata),
    .hdr_raddr(hdr_raddr), .buf_raddr(buf_raddr),
    .data(out_data), .sop(out_sop), .eop(tx_eop)
  );

  assign out_eop = tx_eop;

  // next-state logic
  always_comb begin
    state_d      = state_q;
    dst_d        = dst_q;
    pack_d       = pack_q;
    evcnt_d      = evcnt_q;
    wptr_d       = wptr_q;
    slot_d       = slot_q;
    in_frag_d    = in_frag_q;
    cur_evid_d   = cur_evid_q;
    first_evid_d = first_evid_q;
    flen_d       = flen_q;
    idx_d        = idx_q;
    buf_we       = 1'b0;
    buf_waddr    = wptr_q[BAW-1:0];
    buf_wdata    = frag_data;
    dst_ready    = 1'b0;
    frag_ready   = 1'b0;
    out_valid    = 1'b0;
    busy         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        busy      = !dst_valid;
        dst_ready = dst_valid;
        if (dst_valid) begin
          dst_d     = dst_addr;
          pack_d    = (evt_per_pkt == '0) ? CNT_W'(1) : evt_per_pkt;
          evcnt_d   = '0;
          wptr_d    = '0;
          in_frag_d = 1'b0;
          state_d   = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        frag_ready = 1'b1;
        if (frag_valid) begin
          buf_we = 1'b1;
          if (!in_frag_q) begin
            // reserve the sub-header slot ahead of the first data word
            buf_waddr  = BAW'(wptr_q + PW'(1));
            slot_d     = wptr_q[BAW-1:0];
            cur_evid_d = frag_evid;
            if (evcnt_q == '0) first_evid_d = frag_evid;
            wptr_d     = wptr_q + PW'(2);
            flen_d     = LEN_W'(1);
            in_frag_d  = 1'b1;
          end else begin
            wptr_d = wptr_q + PW'(1);
            flen_d = flen_q + LEN_W'(1);
          end
          if (frag_last) state_d = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        buf_we    = 1'b1;
        buf_waddr = slot_q;
        buf_wdata = DW'({flen_q, cur_evid_q});
        evcnt_d   = evcnt_q + CNT_W'(1);
        in_frag_d = 1'b0;
        if (CNT_W'(evcnt_q + CNT_W'(1)) == pack_q) begin
          idx_d   = '0;
          state_d = ST_SEND;
        end else begin
          state_d = ST_COLLECT;
        end
      end
      ST_SEND: begin
        out_valid = 1'b1;
        if (out_ready) begin
          if (tx_eop) state_d = ST_IDLE;
          else        idx_d   = idx_q + IW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      dst_q        <= '0;
      pack_q       <= CNT_W'(1);
      evcnt_q      <= '0;
      wptr_q       <= '0;
      slot_q       <= '0;
      in_frag_q    <= 1'b0;
      cur_evid_q   <= '0;
      first_evid_q <= '0;
      flen_q       <= '0;
      idx_q        <= '0;
    end else begin
      state_q      <= state_d;
      dst_q        <= dst_d;
      pack_q       <= pack_d;
      evcnt_q      <= evcnt_d;
      wptr_q       <= wptr_d;
      slot_q       <= slot_d;
      in_frag_q    <= in_frag_d;
      cur_evid_q   <= cur_evid_d;
      first_evid_q <= first_evid_d;
      flen_q       <= flen_d;
      idx_q        <= idx_d;
    end
  end
endmodule

// File: rtl/mep_framer_chk.sv
module mep_framer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dst_valid,
  input logic          dst_ready,
  input logic          frag_valid,
  input logic          frag_ready,
  input logic          frag_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sop,
  input logic          out_eop,
  input logic          busy
);
  assert_pop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_ready |-> dst_valid);

  assert_stall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!frag_ready && !out_valid && !dst_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  assert_sop_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !out_eop);

  assert_gap_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> !out_valid);

  assert_no_frag_in_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(frag_ready && out_valid));

  assert_close_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && frag_ready && frag_last) |=> !frag_ready);
endmodule

bind mep_framer mep_framer_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_mep_framer.sv
`timescale 1ns/1ps
module sim_mep_framer;
  localparam int          DW   = 32;
  localparam int          HDR  = 4;
  localparam int          DEP  = 64;
  localparam int          CW   = 6;
  localparam logic [31:0] TRL  = 32'hE0F0_A55A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] evt_per_pkt;
  logic          hdr_we;
  logic [1:0]    hdr_waddr;
  logic [DW-1:0] hdr_wdata;
  logic          dst_valid, dst_ready;
  logic [DW-1:0] dst_addr;
  logic          frag_valid, frag_ready, frag_last;
  logic [DW-1:0] frag_data;
  logic [15:0]   frag_evid;
  logic          out_valid, out_ready, out_sop, out_eop, busy;
  logic [DW-1:0] out_data;

  int   checks = 0;
  int   errs   = 0;
  int   pops   = 0;
  bit   done   = 1'b0;
  bit   rnd_stall = 1'b0;
  logic [33:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  mep_framer #(.DW(DW), .HDR_WORDS(HDR), .BUF_DEPTH(DEP), .CNT_W(CW), .TRAILER(TRL)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_per_pkt(evt_per_pkt),
    .hdr_we(hdr_we), .hdr_waddr(hdr_waddr), .hdr_wdata(hdr_wdata),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_data(frag_data),
    .frag_last(frag_last), .frag_evid(frag_evid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_val(input int i);
    return 32'h4500_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  function automatic int frag_len(input int e, input int lmod);
    return 1 + ((e * 3) % lmod);
  endfunction

  function automatic logic [31:0] word_val(input int evid, input int k);
    return {16'(evid), 16'(k) ^ 16'hA5A5};
  endfunction

  task automatic expect_word(input logic [31:0] d, input bit s, input bit e, input string tag);
    q_exp.push_back({s, e, d});
    q_tag.push_back(tag);
  endtask

  task automatic push_word(input logic [31:0] d, input int evid, input bit last);
    frag_valid = 1'b1; frag_data = d; frag_evid = 16'(evid); frag_last = last;
    #1;
    while (!frag_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  // Builds the expected packet, then drives destination and fragments.
  task automatic run_pkt(input logic [31:0] dst, input int sel, input int nev,
                         input int evid0, input int lmod, input int mid_sel);
    int payload = 0;
    for (int e = 0; e < nev; e++) payload += 1 + frag_len(e, lmod);
    for (int i = 0; i < HDR; i++) expect_word(hdr_val(i), i == 0, 1'b0, "R4");
    expect_word(dst, 1'b0, 1'b0, "R4");
    expect_word({16'(payload), 16'(nev)}, 1'b0, 1'b0, "R5");
    expect_word({16'(evid0), 16'h0000}, 1'b0, 1'b0, "R6");
    for (int e = 0; e < nev; e++) begin
      expect_word({16'(frag_len(e, lmod)), 16'(evid0 + e)}, 1'b0, 1'b0, "R7");
      for (int k = 0; k < frag_len(e, lmod); k++)
        expect_word(word_val(evid0 + e, k), 1'b0, 1'b0, "R7");
    end
    expect_word(TRL, 1'b0, 1'b1, "R8");
    // destination handshake; the factor is changed right after it (R9)
    dst_valid = 1'b1; dst_addr = dst; evt_per_pkt = CW'(sel);
    #1;
    while (!dst_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    dst_valid = 1'b0; evt_per_pkt = CW'(mid_sel);
    for (int e = 0; e < nev; e++)
      for (int k = 0; k < frag_len(e, lmod); k++)
        push_word(word_val(evid0 + e, k), evid0 + e, k == frag_len(e, lmod) - 1);
    frag_valid = 1'b0; frag_last = 1'b0;
  endtask

  // downstream ready pattern
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rnd_stall ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (dst_valid && dst_ready) pops++;
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          chk(1'b0, "R10 unexpected word", {out_sop, out_eop, out_data}, 34'h0);
        end else begin
          logic [33:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          chk({out_sop, out_eop, out_data} === e, t, {out_sop, out_eop, out_data}, e);
        end
        if (out_sop) chk(frag_ready == 1'b0, "R11 frag_ready during send", 34'(frag_ready), 34'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", q_exp.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_per_pkt = '0; hdr_we = 1'b0; hdr_waddr = '0; hdr_wdata = '0;
    dst_valid = 1'b0; dst_addr = '0; frag_valid = 1'b0; frag_data = '0;
    frag_last = 1'b0; frag_evid = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !frag_ready && !dst_ready && busy, "R1 reset outputs",
        34'({out_valid, frag_ready, dst_ready, busy}), 34'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !frag_ready && !dst_ready && busy, "R1 after reset",
        34'({out_valid, frag_ready, dst_ready, busy}), 34'b0001);
    for (int i = 0; i < HDR; i++) begin
      hdr_we = 1'b1; hdr_waddr = 2'(i); hdr_wdata = hdr_val(i);
      @(negedge clk);
    end
    hdr_we = 1'b0;
    // R2: offered fragment without a destination must not be taken
    frag_valid = 1'b1; frag_data = 32'hDEAD_BEEF; frag_evid = 16'h7777; frag_last = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!frag_ready && busy && !out_valid, "R2 stalled without destination",
          34'({frag_ready, busy, out_valid}), 34'b010);
    end
    frag_valid = 1'b0; frag_last = 1'b0;

    run_pkt(32'hC0A8_0001, 2, 2, 16'h0100, 3, 2);            // R5 R7 two events
    rnd_stall = 1'b1;
    run_pkt(32'hC0A8_0002, 3, 3, 16'h0200, 4, 3);            // R10 with stalls
    run_pkt(32'hC0A8_0003, 0, 1, 16'h0300, 5, 0);            // R9 zero means one
    run_pkt(32'hC0A8_0004, 2, 2, 16'h0400, 4, 5);            // R9 late change ignored
    rnd_stall = 1'b0;
    run_pkt(32'hC0A8_0005, 32, 32, 16'hFFF0, 1, 32);         // R5 full buffer, evid wrap
    rnd_stall = 1'b1;
    run_pkt(32'hC0A8_0006, 1, 1, 16'h0600, 1, 1);            // R8 smallest packet

    while (q_exp.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(pops == 6, "R3 one destination per packet", 34'(pops), 34'd6);
    chk(busy && !out_valid && !frag_ready, "R2 idle after last packet",
        34'({busy, out_valid, frag_ready}), 34'b100);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule